// File: doc/BRIEF.md
# Serial Gain-Control Word Decoder

This block takes 8-bit control words from a three-wire serial link and turns them into four stored 4-bit gain codes. The link has a serial clock, a data line and a load strobe. The strobe comes in two forms, an active-high pin and an active-low pin, and a board wires up whichever one suits it. Bits are shifted into a holding register while the strobe is idle. The word reaches a channel register only when the strobe returns to its idle level.

At that moment the word is screened. Its top bit is an enable marker and must be 1. The bit below it names the device and must match the level on the device-select pin. Because of this check, two of these blocks can share one serial bus. The next two bits pick one of four channels, and the low four bits are written to that channel as its gain code. Code zero is reserved as the off state, and each channel has a mute output that shows it.

Every input crosses into the system clock domain through a two-flop synchronizer before any edge is detected. The system clock must therefore run several times faster than the serial clock's shortest high or low phase.

Top module: `gain_word_decoder`

## Requirements
- R1: Word bits are taken most significant bit first, one bit on each rising edge of the serial clock; the first bit shifted in ends up as bit 7 of the word.
- R2: A word whose bit 7 is 0 is dropped when the strobe completes, and no channel register changes.
- R3: A word is written only when its bit 6 equals the level on `dev_sel_i`; a mismatching word leaves every channel register unchanged.
- R4: Bits 5:4 of the word choose the channel: 00 is channel 1, 01 is channel 2, 10 is channel 3 and 11 is channel 4. Channel n appears on `gain_o[4n-1:4n-4]`.
- R5: Bits 3:0 of an accepted word become the selected channel's gain code without change. 0000 means off, 0001 to 1111 are rising gain steps, and 1000 is the unity step.
- R6: With the active-high strobe, a word is written on the strobe's falling edge and not while the strobe is high.
- R7: With the active-low strobe, a word is written on the strobe's rising edge and not while the strobe is low.
- R8: Shifting bits without a strobe edge never changes any channel register.
- R9: Reset clears all four channel codes to 0000, so every channel starts muted.
- R10: `mute_o[n-1]` is 1 exactly when channel n holds code 0000.
- R11: When more than 8 bits are shifted before a strobe, only the last 8 bits received form the evaluated word.
- R12: A single strobe edge changes at most one channel register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Serial bit clock; data is taken on its rising edge |
| ser_dat_i | input | 1 | Serial data, most significant bit first |
| strb_hi_i | input | 1 | Active-high load strobe; the word is written on its falling edge (tie low if unused) |
| strb_lo_n_i | input | 1 | Active-low load strobe; the word is written on its rising edge (tie high if unused) |
| dev_sel_i | input | 1 | Device-select level that word bit 6 must match |
| gain_o | output | 16 | Four 4-bit gain codes; channel 1 in bits 3:0 |
| mute_o | output | 4 | Per-channel off flag; bit 0 is channel 1 |

## Verification
On every cycle the assertions check four things: channel registers hold still unless a strobe edge occurred one cycle earlier, a commit changes at most one channel, the mute flags follow the stored codes, and words that fail screening on the enable bit or the device bit write nothing. An accepted commit is also checked to land the low nibble in the channel named by bits 5:4. Three behaviours are shown only by the bench scenarios: the bit order on the wire, that only the last eight bits count after an over-long shift, and the strobe polarity rules (no write while the strobe is active, a write on its release).

// File: rtl/gwd_pkg.sv
// Package: shared defaults for the serial gain-control word decoder.
// Assumes the word layout is: enable marker, device bit, channel index, gain code
// (most significant field first), so the word width follows from the other sizes.
package gwd_pkg;
    parameter int unsigned GWD_CODE_W      = 4;  // bits per gain code
    parameter int unsigned GWD_N_CH        = 4;  // number of channel registers
    parameter int unsigned GWD_SYNC_STAGES = 2;  // synchronizer depth for every input

    // Width of the channel index field for a given channel count (at least 1).
    function automatic int unsigned gwd_ch_bits(input int unsigned n_ch);
        return (n_ch < 2) ? 1 : $clog2(n_ch);
    endfunction
endpackage

// File: rtl/gwd_sync.sv
// Module: gwd_sync
// Brings a bundle of asynchronous single-bit inputs into the system clock domain
// through a chain of STAGES flops per bit. Assumes each bit is independent and
// that RST_VAL gives the idle level of each bit, so no false edge follows reset.
module gwd_sync #(
    parameter int unsigned   W       = 1,
    parameter int unsigned   STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    // Shift every input bit through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= RST_VAL;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gwd_shifter.sv
// Module: gwd_shifter
// Holds the most recent WORD_W serial bits. On each rising edge of the
// synchronized serial clock it shifts left and places the data bit in the LSB,
// so the first bit sent ends up as the MSB. Older bits fall off the top.
// Assumes the data input is already synchronized with the same latency as the clock.
module gwd_shifter #(
    parameter int unsigned WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sdat_s,
    output logic [WORD_W-1:0] word_o
);
    logic sclk_q;
    logic sclk_rise;

    assign sclk_rise = sclk_s & ~sclk_q;

    // Remember the previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end

    // Shift one data bit in on every serial clock rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)         word_o <= '0;
        else if (sclk_rise) word_o <= {word_o[WORD_W-2:0], sdat_s};
    end
endmodule

// File: rtl/gwd_strobe.sv
// Module: gwd_strobe
// Produces a one-cycle commit pulse when either load strobe returns to idle:
// the falling edge of the active-high strobe or the rising edge of the
// active-low strobe. Assumes the unused strobe is held at its idle level.
module gwd_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_hi_s,
    input  logic stb_lo_n_s,
    output logic commit_o
);
    logic hi_q;
    logic lo_n_q;

    // Keep the previous strobe levels; reset to the idle levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q   <= 1'b0;
            lo_n_q <= 1'b1;
        end else begin
            hi_q   <= stb_hi_s;
            lo_n_q <= stb_lo_n_s;
        end
    end

    // A strobe returning to idle on either pin is a commit.
    always_comb begin
        commit_o = (hi_q & ~stb_hi_s) | (~lo_n_q & stb_lo_n_s);
    end
endmodule

// File: rtl/gwd_regbank.sv
// Module: gwd_regbank
// Screens a completed word and writes its gain code into one channel register.
// A write happens only on a commit pulse when the enable marker is 1 and the
// device bit matches dev_sel_i. Code zero marks a channel as muted.
// Assumes N_CH >= 2 and WORD_W = 2 + channel-index width + CODE_W.
module gwd_regbank #(
    parameter int unsigned N_CH   = 4,
    parameter int unsigned CODE_W = 4,
    parameter int unsigned WORD_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     commit_i,
    input  logic [WORD_W-1:0]        word_i,
    input  logic                     dev_sel_i,
    output logic [N_CH*CODE_W-1:0]   gain_o,
    output logic [N_CH-1:0]          mute_o
);
    localparam int unsigned CH_W    = WORD_W - 2 - CODE_W;
    localparam int unsigned EN_BIT  = WORD_W - 1;
    localparam int unsigned DEV_BIT = WORD_W - 2;

    logic              accept;
    logic [CH_W-1:0]   ch_idx;
    logic [CODE_W-1:0] new_code;

    // Screen the word against the enable marker and the device select level.
    always_comb begin
        accept   = commit_i & word_i[EN_BIT] & (word_i[DEV_BIT] == dev_sel_i);
        ch_idx   = word_i[CODE_W +: CH_W];
        new_code = word_i[CODE_W-1:0];
    end

    for (genvar g = 0; g < int'(N_CH); g++) begin : g_ch
        logic [CODE_W-1:0] code_q;

        // Load this channel's code when an accepted word addresses it.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  code_q <= '0;
            else if (accept && (ch_idx == CH_W'(g)))     code_q <= new_code;
        end

        assign gain_o[g*CODE_W +: CODE_W] = code_q;
        assign mute_o[g]                  = (code_q == '0);
    end
endmodule

// File: rtl/gain_word_decoder.sv
// Module: gain_word_decoder (top)
// Serial gain-control word decoder: synchronizes the serial clock, data, both
// load strobes and the device select into clk, assembles 8-bit words MSB first,
// and commits a screened word to one of four channel gain registers when a
// strobe returns to idle. Assumes clk is several times faster than the
// shortest serial clock phase and strobe pulse.
module gain_word_decoder
    import gwd_pkg::*;
#(
    parameter int unsigned CODE_W      = GWD_CODE_W,
    parameter int unsigned N_CH        = GWD_N_CH,
    parameter int unsigned SYNC_STAGES = GWD_SYNC_STAGES
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ser_clk_i,
    input  logic                   ser_dat_i,
    input  logic                   strb_hi_i,
    input  logic                   strb_lo_n_i,
    input  logic                   dev_sel_i,
    output logic [N_CH*CODE_W-1:0] gain_o,
    output logic [N_CH-1:0]        mute_o
);
    localparam int unsigned CH_W   = gwd_ch_bits(N_CH);
    localparam int unsigned WORD_W = 2 + CH_W + CODE_W;
    localparam int unsigned N_IN   = 5;
    // Idle levels in order {serial clock, data, high strobe, low strobe, select}.
    localparam logic [N_IN-1:0] IN_IDLE = 5'b0_0_0_1_0;

    logic              sclk_s, sdat_s, stb_hi_s, stb_lo_n_s, sel_s;
    logic [WORD_W-1:0] word_q;
    logic              commit_evt;

    gwd_sync #(
        .W       (N_IN),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (IN_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({ser_clk_i, ser_dat_i, strb_hi_i, strb_lo_n_i, dev_sel_i}),
        .q_o   ({sclk_s, sdat_s, stb_hi_s, stb_lo_n_s, sel_s})
    );

    gwd_shifter #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_s (sclk_s),
        .sdat_s (sdat_s),
        .word_o (word_q)
    );

    gwd_strobe u_strobe (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb_hi_s   (stb_hi_s),
        .stb_lo_n_s (stb_lo_n_s),
        .commit_o   (commit_evt)
    );

    gwd_regbank #(
        .N_CH   (N_CH),
        .CODE_W (CODE_W),
        .WORD_W (WORD_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_i  (commit_evt),
        .word_i    (word_q),
        .dev_sel_i (sel_s),
        .gain_o    (gain_o),
        .mute_o    (mute_o)
    );
endmodule

// File: rtl/gwd_checker.sv
// Module: gwd_checker
// Property checks for gain_word_decoder, attached by bind below. It observes the
// commit pulse, the assembled word and the synchronized select, and relates them
// to the gain and mute outputs one cycle later.
module gwd_checker #(
    parameter int unsigned N_CH   = 4,
    parameter int unsigned CODE_W = 4,
    parameter int unsigned WORD_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   commit_evt,
    input logic [WORD_W-1:0]      word_q,
    input logic                   sel_s,
    input logic [N_CH*CODE_W-1:0] gain_o,
    input logic [N_CH-1:0]        mute_o
);
    localparam int unsigned CH_W = WORD_W - 2 - CODE_W;

    logic                   cmt_q, acc_q, no_en_q, bad_dev_q;
    logic [CH_W-1:0]        ch_q;
    logic [CODE_W-1:0]      code_q;
    logic [N_CH*CODE_W-1:0] gain_prev;
    logic [N_CH-1:0]        chg;
    logic [CODE_W-1:0]      hit_code;

    // Record last cycle's commit, its screening result and the outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmt_q <= 1'b0; acc_q <= 1'b0; no_en_q <= 1'b0; bad_dev_q <= 1'b0;
            ch_q <= '0; code_q <= '0; gain_prev <= '0;
        end else begin
            cmt_q     <= commit_evt;
            no_en_q   <= commit_evt & ~word_q[WORD_W-1];
            bad_dev_q <= commit_evt & (word_q[WORD_W-2] != sel_s);
            acc_q     <= commit_evt & word_q[WORD_W-1] & (word_q[WORD_W-2] == sel_s);
            ch_q      <= word_q[CODE_W +: CH_W];
            code_q    <= word_q[CODE_W-1:0];
            gain_prev <= gain_o;
        end
    end

    // Per-channel change flags and the code of the channel last addressed.
    always_comb begin
        for (int i = 0; i < int'(N_CH); i++)
            chg[i] = (gain_o[i*CODE_W +: CODE_W] != gain_prev[i*CODE_W +: CODE_W]);
        hit_code = gain_o[ch_q*CODE_W +: CODE_W];
    end

    p_hold_without_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cmt_q |-> (gain_o == gain_prev));

    p_drop_no_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        no_en_q |-> (gain_o == gain_prev));

    p_drop_wrong_device_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bad_dev_q |-> (gain_o == gain_prev));

    // R4 and R5: the accepted code lands in the addressed channel.
    p_write_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q |-> (hit_code == code_q));

    p_single_channel_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(chg) <= 1);

    for (genvar g = 0; g < int'(N_CH); g++) begin : g_mute
        p_mute_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
            mute_o[g] == (gain_o[g*CODE_W +: CODE_W] == '0));
    end
endmodule

bind gain_word_decoder gwd_checker #(
    .N_CH   (N_CH),
    .CODE_W (CODE_W),
    .WORD_W (WORD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit_evt (commit_evt),
    .word_q     (word_q),
    .sel_s      (sel_s),
    .gain_o     (gain_o),
    .mute_o     (mute_o)
);

// File: tb/gain_word_decoder_tb.sv
// Bench for gain_word_decoder: a table of serial words with expected gain images,
// walked by one loop, then directed tests for strobe timing, over-long shifts and reset.
module gain_word_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0, ser_dat = 1'b0, strb_hi = 1'b0, strb_lo_n = 1'b1, dev_sel = 1'b0;
    logic [15:0] gain;
    logic [3:0]  mute;
    int          n_checks = 0, n_errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    gain_word_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
        .strb_hi_i(strb_hi), .strb_lo_n_i(strb_lo_n), .dev_sel_i(dev_sel),
        .gain_o(gain), .mute_o(mute)
    );

    // Entry: [25] use active-low strobe, [24] device select, [23:16] word,
    // [15:0] expected gain image {ch4,ch3,ch2,ch1}.
    localparam int NV = 10;
    localparam logic [25:0] VEC [NV] = '{
        {2'b00, 8'h88, 16'h0008},
        {2'b00, 8'h93, 16'h0038},
        {2'b10, 8'hAF, 16'h0F38},
        {2'b10, 8'hB1, 16'h1F38},
        {2'b00, 8'h35, 16'h1F38},
        {2'b00, 8'hC6, 16'h1F38},
        {2'b01, 8'hC6, 16'h1F36},
        {2'b11, 8'hBC, 16'h1F36},
        {2'b11, 8'hF0, 16'h0F36},
        {2'b00, 8'h9A, 16'h0FA6}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R1 R5 R6 ch1 unity";
            1: return "R4 ch2";
            2: return "R7 ch3";
            3: return "R7 R12 ch4";
            4: return "R2 enable bit clear";
            5: return "R3 device mismatch";
            6: return "R3 device match";
            7: return "R3 mismatch sel=1";
            8: return "R10 ch4 off";
            default: return "R4 R12 ch2 rewrite";
        endcase
    endfunction

    function automatic logic [3:0] mute_of(input logic [15:0] g);
        for (int i = 0; i < 4; i++) mute_of[i] = (g[i*4 +: 4] == 4'h0);
    endfunction

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Shift nbits of val, most significant first.
    task automatic send_bits(input logic [15:0] val, input int nbits);
        for (int b = nbits - 1; b >= 0; b--) begin
            ser_dat = val[b];
            wait_clks(3);
            ser_clk = 1'b1;
            wait_clks(4);
            ser_clk = 1'b0;
            wait_clks(3);
        end
    endtask

    task automatic pulse_hi();
        strb_hi = 1'b1; wait_clks(6);
        strb_hi = 1'b0; wait_clks(6);
    endtask

    task automatic pulse_lo();
        strb_lo_n = 1'b0; wait_clks(6);
        strb_lo_n = 1'b1; wait_clks(6);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        wait_clks(4);
        check("R9 reset gain", 32'(gain), 32'h0000);
        check("R9 reset mute", 32'(mute), 32'hF);
        rst_n = 1'b1;
        wait_clks(4);

        for (int i = 0; i < NV; i++) begin
            dev_sel = VEC[i][24];
            wait_clks(4);
            send_bits(16'(VEC[i][23:16]), 8);
            if (VEC[i][25]) pulse_lo(); else pulse_hi();
            check(vec_tag(i), 32'(gain), 32'(VEC[i][15:0]));
            check({vec_tag(i), " R10 mute"}, 32'(mute), 32'(mute_of(VEC[i][15:0])));
        end

        // R8: a full word shifted with no strobe writes nothing.
        send_bits(16'h008D, 8);
        wait_clks(6);
        check("R8 shift without strobe", 32'(gain), 32'h0FA6);
        // R6: nothing while the high strobe is active; write on its fall.
        strb_hi = 1'b1; wait_clks(8);
        check("R6 no write while high", 32'(gain), 32'h0FA6);
        strb_hi = 1'b0; wait_clks(6);
        check("R6 write on fall", 32'(gain), 32'h0FAD);

        // R7: nothing while the low strobe is active; write on its rise.
        send_bits(16'h00A2, 8);
        strb_lo_n = 1'b0; wait_clks(8);
        check("R7 no write while low", 32'(gain), 32'h0FAD);
        strb_lo_n = 1'b1; wait_clks(6);
        check("R7 write on rise", 32'(gain), 32'h02AD);

        // R11: twelve bits shifted; only the last eight (B5: ch4 code 5) count.
        send_bits(16'h0FB5, 12);
        pulse_hi();
        check("R11 last eight bits", 32'(gain), 32'h52AD);
        check("R11 R10 mute", 32'(mute), 32'h0);

        // R9: reset during operation clears all channels.
        rst_n = 1'b0; wait_clks(3);
        rst_n = 1'b1; wait_clks(2);
        check("R9 re-reset gain", 32'(gain), 32'h0000);
        check("R9 re-reset mute", 32'(mute), 32'hF);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule